// File: doc/BRIEF.md
# Interleaved Four-Point Stencil Pipeline

This block updates one strip of a two-dimensional grid with a weighted four-neighbour stencil. Each new value is the sum of the point above, left, right and below, each scaled by its own weight. The strip is exactly as wide as the arithmetic pipelines are deep. One pipelined multiplier and one pipelined adder serve all points and all four neighbours. Eight consecutive points are fed through them in four passes of eight cycles each, so both units stay busy with no duplicated hardware.

The grid sits in a local word memory as two planes. The input plane holds the previous time step, including a one-point border of fixed boundary values. The output plane receives the new values. The block fetches neighbour words through a synchronous read port and writes finished results through a write port. It ends each run with a single done pulse. Successive rows overlap, so the multiplier accepts a new operand in every cycle of a run. The partial sums of one row drain through the adder while the next row starts.

Top module: `stencil4_strip`

## Requirements
- R1: Each result is (w_up·up + w_left·left + w_right·right + w_down·down) >>> FRAC, truncated to DW bits. The terms are signed DW-bit words, sum and shift are arithmetic, and the defaults are DW=16 and FRAC=8.
- R2: A plane is (ROWS+2)×(DEPTH+2) words, stored row-major at offset r·(DEPTH+2)+c. The input plane starts at address 0 and the output plane starts at (ROWS+2)·(DEPTH+2). Interior points are rows 1..ROWS and columns 1..DEPTH.
- R3: Writes go only to interior points of the output plane. Border words of both planes and the whole input plane are never written.
- R4: Reads address only the input plane. rd_en_o is high for exactly 4·DEPTH·ROWS consecutive cycles, starting in the cycle after the edge that samples start_i. Read data is expected one cycle after its address.
- R5: Each row is read in four passes of DEPTH points, in the order up, left, right, down. Within a pass the points go left to right, and rows go top to bottom.
- R6: The first write appears 5·DEPTH+1 cycles after the start edge. Each row writes its DEPTH results in consecutive cycles, and successive rows begin 4·DEPTH cycles apart.
- R7: done_o is high for exactly one cycle, the cycle right after the last write of the run.
- R8: start_i asserted while a run is in progress has no effect on reads, writes or the done timing.
- R9: While rst_ni is low, rd_en_o, wr_en_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run when idle |
| w_up_i | input | DW | Weight for the point above |
| w_left_i | input | DW | Weight for the point to the left |
| w_right_i | input | DW | Weight for the point to the right |
| w_down_i | input | DW | Weight for the point below |
| rd_en_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read word address |
| rd_data_i | input | DW | Read data, one cycle after the address |
| wr_en_o | output | 1 | Write strobe |
| wr_addr_o | output | AW | Write word address |
| wr_data_o | output | DW | Result word |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The assertions take three things for granted: the memory returns data exactly one cycle after the address, the weights stay constant for the whole run, and the strip width equals the pipeline depth. The recirculation check depends on all three for the partial sum and the new product of the same point to meet at the adder. The bench models a one-cycle synchronous memory and sets the weights only while the block is idle. It also leaves the depth at its default value, which fixes the strip width to match.

// File: rtl/stencil4_pkg.sv
package stencil4_pkg;
  // Neighbour pass order; value also indexes the weight vector
  typedef enum logic [1:0] {
    NB_UP    = 2'd0,
    NB_LEFT  = 2'd1,
    NB_RIGHT = 2'd2,
    NB_DOWN  = 2'd3
  } nb_e;
endpackage

// File: rtl/stencil4_delay.sv
module stencil4_delay #(
  parameter int W = 8,
  parameter int N = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [N];

  for (genvar i = 0; i < N; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else if (i == 0) stg_q[i] <= d_i;
      else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = stg_q[N-1];
endmodule

// File: rtl/stencil4_sched.sv
module stencil4_sched
  import stencil4_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ROWS  = 4,
  parameter int AW    = 7,
  parameter int PTW   = 3,
  parameter int RW    = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  output logic           rd_en_o,
  output logic [AW-1:0]  rd_addr_o,
  output nb_e            pass_o,
  output logic [PTW-1:0] pt_o,
  output logic [RW-1:0]  row_o
);
  localparam int NC = DEPTH + 2;

  logic           busy_q;
  nb_e            pass_q;
  logic [PTW-1:0] pt_q;
  logic [RW-1:0]  row_q;
  logic           last_pt, last_pass, last_row, last_iss;

  assign last_pt   = pt_q == PTW'(DEPTH-1);
  assign last_pass = pass_q == NB_DOWN;
  assign last_row  = row_q == RW'(ROWS-1);
  assign last_iss  = last_pt && last_pass && last_row;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pass_q <= NB_UP;
      pt_q   <= '0;
      row_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        pass_q <= NB_UP;
        pt_q   <= '0;
        row_q  <= '0;
      end
    end else begin
      if (last_iss) busy_q <= 1'b0;
      pt_q <= last_pt ? '0 : pt_q + 1'b1;
      if (last_pt) pass_q <= nb_e'(pass_q + 2'd1);
      if (last_pt && last_pass) row_q <= last_row ? '0 : row_q + 1'b1;
    end
  end

  int center;
  int addr_c;
  always_comb begin
    center = (int'(row_q) + 1) * NC + int'(pt_q) + 1;
    unique case (pass_q)
      NB_UP:    addr_c = center - NC;
      NB_LEFT:  addr_c = center - 1;
      NB_RIGHT: addr_c = center + 1;
      default:  addr_c = center + NC;
    endcase
  end

  assign rd_en_o   = busy_q;
  assign rd_addr_o = AW'(addr_c);
  assign pass_o    = pass_q;
  assign pt_o      = pt_q;
  assign row_o     = row_q;

  // A start during a run must not rewind the issue counters
  p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !last_iss) |=> !(pt_q == '0 && pass_q == NB_UP && row_q == '0));
endmodule

// File: rtl/stencil4_mac.sv
module stencil4_mac
  import stencil4_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int PTW   = 3,
  parameter int RW    = 2,
  parameter int FRAC  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_vld_i,
  input  nb_e                  in_pass_i,
  input  logic [PTW-1:0]       in_pt_i,
  input  logic [RW-1:0]        in_row_i,
  input  logic [DW-1:0]        in_data_i,
  input  logic [3:0][DW-1:0]   w_i,
  output logic                 out_vld_o,
  output logic [PTW-1:0]       out_pt_o,
  output logic [RW-1:0]        out_row_o,
  output logic [DW-1:0]        out_val_o
);
  localparam int PW  = 2 * DW;
  localparam int ACW = PW + 2;
  localparam int TW  = 1 + 2 + PTW + RW;

  // Multiplier pipeline: product plus tag
  logic [TW-1:0]        in_tag;
  logic signed [PW-1:0] prod_c;
  logic [PW+TW-1:0]     mul_q;

  assign in_tag = {in_vld_i, in_pass_i, in_pt_i, in_row_i};
  assign prod_c = $signed(in_data_i) * $signed(w_i[in_pass_i]);

  stencil4_delay #(.W(PW+TW), .N(DEPTH)) u_mul (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({prod_c, in_tag}),
    .q_o   (mul_q)
  );

  logic [PW-1:0]  m_prod;
  logic [TW-1:0]  m_tag;
  logic           m_vld;
  nb_e            m_pass;
  logic [PTW-1:0] m_pt;
  logic [RW-1:0]  m_row;

  assign m_prod = mul_q[TW +: PW];
  assign m_tag  = mul_q[TW-1:0];
  assign m_vld  = m_tag[TW-1];
  assign m_pass = nb_e'(m_tag[TW-2 -: 2]);
  assign m_pt   = m_tag[RW +: PTW];
  assign m_row  = m_tag[RW-1:0];

  // Adder pipeline: partial sum leaving the adder recirculates as operand b
  logic [ACW+TW-1:0] add_q;
  logic [ACW-1:0]    a_sum;
  logic [TW-1:0]     a_tag;
  logic [ACW-1:0]    opnd_b, sum_c;

  assign a_sum  = add_q[TW +: ACW];
  assign a_tag  = add_q[TW-1:0];
  assign opnd_b = (m_pass == NB_UP) ? '0 : a_sum;
  assign sum_c  = m_vld ? ({{(ACW-PW){m_prod[PW-1]}}, m_prod} + opnd_b) : '0;

  stencil4_delay #(.W(ACW+TW), .N(DEPTH)) u_add (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sum_c, m_tag}),
    .q_o   (add_q)
  );

  logic           a_vld;
  nb_e            a_pass;
  logic [PTW-1:0] a_pt;
  logic [RW-1:0]  a_row;
  logic [ACW-1:0] scaled;

  assign a_vld  = a_tag[TW-1];
  assign a_pass = nb_e'(a_tag[TW-2 -: 2]);
  assign a_pt   = a_tag[RW +: PTW];
  assign a_row  = a_tag[RW-1:0];
  assign scaled = $signed(a_sum) >>> FRAC;

  assign out_vld_o = a_vld && (a_pass == NB_DOWN);
  assign out_pt_o  = a_pt;
  assign out_row_o = a_row;
  assign out_val_o = scaled[DW-1:0];

  // Recirculated partial sum must belong to the same point, previous pass
  p_recirc_align_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_vld && m_pass != NB_UP) |-> (a_vld && a_pt == m_pt && a_row == m_row &&
                                    a_pass == nb_e'(m_pass - 2'd1)));
endmodule

// File: rtl/stencil4_strip.sv
module stencil4_strip
  import stencil4_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int ROWS  = 4,
  parameter int FRAC  = 8,
  parameter int AW    = $clog2(2 * (ROWS + 2) * (DEPTH + 2))
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] w_up_i,
  input  logic [DW-1:0] w_left_i,
  input  logic [DW-1:0] w_right_i,
  input  logic [DW-1:0] w_down_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          done_o
);
  localparam int NC       = DEPTH + 2;
  localparam int OUT_BASE = (ROWS + 2) * NC;
  localparam int PTW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int RW       = (ROWS > 1) ? $clog2(ROWS) : 1;

  nb_e            iss_pass;
  logic [PTW-1:0] iss_pt;
  logic [RW-1:0]  iss_row;

  stencil4_sched #(.DEPTH(DEPTH), .ROWS(ROWS), .AW(AW), .PTW(PTW), .RW(RW)) u_sched (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .rd_en_o  (rd_en_o),
    .rd_addr_o(rd_addr_o),
    .pass_o   (iss_pass),
    .pt_o     (iss_pt),
    .row_o    (iss_row)
  );

  // Align tag with the one-cycle read latency
  logic           rv_q;
  nb_e            rpass_q;
  logic [PTW-1:0] rpt_q;
  logic [RW-1:0]  rrow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rv_q    <= 1'b0;
      rpass_q <= NB_UP;
      rpt_q   <= '0;
      rrow_q  <= '0;
    end else begin
      rv_q    <= rd_en_o;
      rpass_q <= iss_pass;
      rpt_q   <= iss_pt;
      rrow_q  <= iss_row;
    end
  end

  logic [3:0][DW-1:0] wvec;
  assign wvec = {w_down_i, w_right_i, w_left_i, w_up_i};

  logic           res_vld;
  logic [PTW-1:0] res_pt;
  logic [RW-1:0]  res_row;
  logic [DW-1:0]  res_val;

  stencil4_mac #(.DW(DW), .DEPTH(DEPTH), .PTW(PTW), .RW(RW), .FRAC(FRAC)) u_mac (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .in_vld_i (rv_q),
    .in_pass_i(rpass_q),
    .in_pt_i  (rpt_q),
    .in_row_i (rrow_q),
    .in_data_i(rd_data_i),
    .w_i      (wvec),
    .out_vld_o(res_vld),
    .out_pt_o (res_pt),
    .out_row_o(res_row),
    .out_val_o(res_val)
  );

  assign wr_en_o   = res_vld;
  assign wr_addr_o = AW'(OUT_BASE + (int'(res_row) + 1) * NC + int'(res_pt) + 1);
  assign wr_data_o = res_val;

  logic done_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else done_q <= res_vld && res_pt == PTW'(DEPTH-1) && res_row == RW'(ROWS-1);
  end
  assign done_o = done_q;

  p_wr_interior_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ((int'(wr_addr_o) - OUT_BASE) >= NC &&
                 (int'(wr_addr_o) - OUT_BASE) < (ROWS + 1) * NC &&
                 (int'(wr_addr_o) - OUT_BASE) % NC != 0 &&
                 (int'(wr_addr_o) - OUT_BASE) % NC != NC - 1));
  p_rd_in_plane_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> int'(rd_addr_o) < OUT_BASE);
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(wr_en_o) && !wr_en_o));
endmodule

// File: tb/stencil4_strip_test.sv
`timescale 1ns/1ps
module stencil4_strip_test;
  localparam int DW = 16, DEPTH = 8, ROWS = 4, FRAC = 8;
  localparam int NC = DEPTH + 2, NR = ROWS + 2;
  localparam int PLANE = NR * NC, AW = $clog2(2 * PLANE);
  localparam int NVEC = 4;
  // {seed, w_up, w_left, w_right, w_down}
  localparam logic [79:0] VEC [NVEC] = '{
    {16'h0001, 16'd256, 16'd256, 16'd256, 16'd256},
    {16'h1234, 16'd64, 16'hFF80, 16'd512, 16'd32},
    {16'hBEEF, 16'd0, 16'd0, 16'd0, 16'd0},
    {16'h7FFF, 16'h7FFF, 16'h8000, 16'h7FFF, 16'h8000}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [DW-1:0] w_up_i = '0, w_left_i = '0, w_right_i = '0, w_down_i = '0;
  logic rd_en_o, wr_en_o, done_o;
  logic [AW-1:0] rd_addr_o, wr_addr_o;
  logic [DW-1:0] rd_data_i = '0, wr_data_o;

  always #2.5 clk_i = ~clk_i;

  stencil4_strip #(.DW(DW), .DEPTH(DEPTH), .ROWS(ROWS), .FRAC(FRAC)) uut (.*);

  logic [DW-1:0] mem [2*PLANE];
  logic [DW-1:0] ref_in [PLANE];
  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  int rd_cnt, wr_cnt, done_cnt, rd_first, rd_last, wr_first, done_cyc;
  int rd_log [4*DEPTH];

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (rd_en_o) rd_data_i <= mem[rd_addr_o];
    if (wr_en_o) mem[wr_addr_o] <= wr_data_o;
  end

  always @(negedge clk_i) begin
    if (rd_en_o) begin
      if (rd_cnt == 0) rd_first = cyc;
      if (rd_cnt < 4*DEPTH) rd_log[rd_cnt] = int'(rd_addr_o);
      rd_last = cyc;
      rd_cnt++;
    end
    if (wr_en_o) begin
      if (wr_cnt == 0) wr_first = cyc;
      wr_cnt++;
    end
    if (done_o) begin
      done_cnt++;
      done_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] data_of(input logic [15:0] seed, input int a);
    logic [31:0] v;
    v = seed * (a + 3) ^ (a << 7) ^ (seed << 3);
    return v[DW-1:0];
  endfunction

  task automatic run_vec(input int n, input bit poke);
    int t0;
    int bad_b, bad_i;
    bit timed_out;
    {w_up_i, w_left_i, w_right_i, w_down_i} = VEC[n][63:0];
    for (int a = 0; a < PLANE; a++) begin
      mem[a] = data_of(VEC[n][79:64], a);
      ref_in[a] = mem[a];
      mem[PLANE + a] = 16'hDEAD;
    end
    @(posedge clk_i);
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0;
    rd_first = -1; rd_last = -1; wr_first = -1; done_cyc = -1;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    t0 = cyc;
    if (poke) begin
      repeat (20) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i); start_i = 1'b0;
    end
    timed_out = 1'b1;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk_i);
      if (done_cnt != 0) begin timed_out = 1'b0; break; end
    end
    chk(!timed_out, "R7 watchdog", timed_out, 0);
    repeat (4) @(negedge clk_i);

    // R1/R2: values at interior output words
    for (int r = 1; r <= ROWS; r++) begin
      for (int c = 1; c <= DEPTH; c++) begin
        longint s;
        logic [DW-1:0] e;
        int ce;
        ce = r * NC + c;
        s = longint'($signed(w_up_i))    * longint'($signed(ref_in[ce-NC])) +
            longint'($signed(w_left_i))  * longint'($signed(ref_in[ce-1])) +
            longint'($signed(w_right_i)) * longint'($signed(ref_in[ce+1])) +
            longint'($signed(w_down_i))  * longint'($signed(ref_in[ce+NC]));
        e = DW'(s >>> FRAC);
        chk(mem[PLANE+ce] == e, "R1 R2 result", mem[PLANE+ce], e);
      end
    end
    // R3: borders of output plane and whole input plane untouched
    bad_b = 0; bad_i = 0;
    for (int a = 0; a < PLANE; a++) begin
      if (mem[a] != ref_in[a]) bad_i++;
      if ((a / NC == 0 || a / NC == NR-1 || a % NC == 0 || a % NC == NC-1) &&
          mem[PLANE+a] != 16'hDEAD) bad_b++;
    end
    chk(bad_b == 0, "R3 output border", bad_b, 0);
    chk(bad_i == 0, "R3 input plane", bad_i, 0);
    chk(wr_cnt == ROWS*DEPTH, "R3 write count", wr_cnt, ROWS*DEPTH);
    // R4: gapless read window
    chk(rd_cnt == 4*DEPTH*ROWS, "R4 read count", rd_cnt, 4*DEPTH*ROWS);
    chk(rd_first - t0 == 0, "R4 first read", rd_first - t0, 0);
    chk(rd_last - t0 == 4*DEPTH*ROWS-1, "R4 last read", rd_last - t0, 4*DEPTH*ROWS-1);
    // R5: first row pass order up, left, right, down
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < DEPTH; i++) begin
        int ce, ea;
        ce = NC + i + 1;
        ea = (p == 0) ? ce - NC : (p == 1) ? ce - 1 : (p == 2) ? ce + 1 : ce + NC;
        chk(rd_log[p*DEPTH+i] == ea, "R5 read order", rd_log[p*DEPTH+i], ea);
      end
    end
    // R6/R7: timing
    chk(wr_first - t0 == 5*DEPTH+1, "R6 first write", wr_first - t0, 5*DEPTH+1);
    chk(done_cyc - t0 == 4*DEPTH*ROWS + 2*DEPTH + 1, "R7 done cycle",
        done_cyc - t0, 4*DEPTH*ROWS + 2*DEPTH + 1);
    chk(done_cnt == 1, poke ? "R8 single done" : "R7 single done", done_cnt, 1);
  endtask

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk_i);
    chk(rd_en_o == 1'b0, "R9 rd_en in reset", rd_en_o, 0);
    chk(wr_en_o == 1'b0, "R9 wr_en in reset", wr_en_o, 0);
    chk(done_o == 1'b0, "R9 done in reset", done_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(rd_en_o == 1'b0, "R9 idle after reset", rd_en_o, 0);

    for (int n = 0; n < NVEC; n++) run_vec(n, 1'b0);

    // R8: start pulse mid-run leaves counts and timing unchanged
    run_vec(1, 1'b1);
    repeat (10) @(negedge clk_i);
    chk(rd_en_o == 1'b0, "R8 idle after run", rd_en_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule